// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This unit keeps the running time of a processor core. It holds two free-running 64-bit time bases, a main one and an alternate one, that advance by one on every cycle in which the external tick enable is high and the freeze input is low. It also holds two 32-bit down-counters, a decrementer and a hypervisor decrementer, and a 64-bit utilisation counter. The counters share the same tick.

Software reaches the time bases and the decrementers through a 32-bit register port. The port has a write strobe with a select code and a combinational read path with its own select code. Each decrementer raises a one-cycle interrupt pulse in two cases. The first is when it counts down past zero. The second is when a write turns its sign bit from clear to set. A legacy real-time-clock view shows the low word of the main time base with only bits 29..7 kept.

The utilisation counter is loaded from a dedicated 64-bit input and then advances on the tick. Producing the tick from a reference clock is left to the surrounding logic.

Top module: `tbdec_unit`

## Requirements
- R1: After reset both time bases and the utilisation counter read zero, both decrementers read 0xFFFFFFFF, and neither interrupt output is high.
- R2: The main time base (select 0 = low word, select 1 = high word) grows by exactly one per cycle with tick high and freeze low, carrying from the low word into the high word.
- R3: Writing one word of a time base replaces that word and leaves the other word unchanged. In a cycle with such a write, the tick does not advance that time base.
- R4: The alternate time base (select 2 = low word, select 3 = high word) is written and read independently of the main time base and counts on the same tick.
- R5: While freeze is high both time bases hold their values. After freeze falls they continue from the held values with no jump.
- R6: The decrementer (select 4) falls by one per tick. A tick at zero reloads 0xFFFFFFFF and pulses dec_irq in the following cycle.
- R7: A decrementer write loads the written value and takes priority over a tick in the same cycle. It pulses dec_irq in the next cycle only when the written bit 31 is set and the previous bit 31 was clear.
- R8: The hypervisor decrementer (select 5) obeys R6 and R7 but drives hdec_irq, and it never drives dec_irq.
- R9: util_load copies util_value into the utilisation counter, taking priority over the tick. Otherwise the counter grows by one per tick, whatever the state of freeze.
- R10: The clock view low word (select 6) reads and writes the main low word masked with 0x3FFFFF80. The clock view high word (select 7) is the main high word.
- R11: Each interrupt output is high for no more than one cycle at a time.
- R12: Select codes 8 to 15 read zero, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for all counters |
| freeze | input | 1 | Holds both time bases while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for the read |
| rd_data | output | 32 | Combinational read data |
| util_load | input | 1 | Loads the utilisation counter |
| util_value | input | 64 | Load value for the utilisation counter |
| util_count | output | 64 | Utilisation counter value |
| dec_irq | output | 1 | Decrementer interrupt pulse |
| hdec_irq | output | 1 | Hypervisor decrementer interrupt pulse |

## Verification
Every counter update, including writes, loads, ticks and reloads after a wrap, takes effect at the clock edge that samples it. Because the read path is combinational, the new value is visible right after that edge. An interrupt pulse appears in the cycle after the edge that caught the wrap or the sign-changing write, and it is gone one cycle later. The bench drives each stimulus just after a rising edge and waits for exactly one edge. It then samples a moment later, checking the pulse in that cycle and its absence in the next one.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
    parameter int unsigned SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_TB_LO  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_TB_HI  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ATB_LO = 4'd2;
    localparam logic [SEL_W-1:0] SEL_ATB_HI = 4'd3;
    localparam logic [SEL_W-1:0] SEL_DEC    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_HDEC   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_RTC_LO = 4'd6;
    localparam logic [SEL_W-1:0] SEL_RTC_HI = 4'd7;

    localparam int unsigned NUM_TB  = 2;
    localparam int unsigned NUM_DEC = 2;
endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_en,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [2*DATA_W-1:0]   value
);
    localparam int unsigned TB_W = 2 * DATA_W;

    typedef struct packed {
        logic [TB_W-1:0] count;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            // a write to either word suppresses the increment this cycle
            if (wr_lo) st_d.count[DATA_W-1:0]    = wr_data;
            if (wr_hi) st_d.count[TB_W-1:DATA_W] = wr_data;
        end else if (cnt_en) begin
            st_d.count = st_q.count + {{(TB_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.count;
endmodule

// File: rtl/tbdec_down.sv
module tbdec_down #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    localparam int unsigned MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              pulse;
    } dn_state_t;

    dn_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            st_d.count = wr_data;
            st_d.pulse = wr_data[MSB] & ~st_q.count[MSB];
        end else if (tick) begin
            if (st_q.count == '0) begin
                st_d.count = '1;
                st_d.pulse = 1'b1;
            end else begin
                st_d.count = st_q.count - {{(DATA_W-1){1'b0}}, 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.count;
    assign irq   = st_q.pulse;
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int unsigned       DATA_W   = 32,
    parameter logic [DATA_W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                freeze,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                util_load,
    input  logic [2*DATA_W-1:0] util_value,
    output logic [2*DATA_W-1:0] util_count,
    output logic                dec_irq,
    output logic                hdec_irq
);
    localparam int unsigned TB_W = 2 * DATA_W;

    typedef struct packed {
        logic [TB_W-1:0] util;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              tb_run;
    logic              tb_wr_lo  [NUM_TB];
    logic              tb_wr_hi  [NUM_TB];
    logic [DATA_W-1:0] tb_wdata  [NUM_TB];
    logic [TB_W-1:0]   tb_val    [NUM_TB];
    logic              dn_wr     [NUM_DEC];
    logic [DATA_W-1:0] dn_val    [NUM_DEC];
    logic              dn_irq    [NUM_DEC];

    logic [TB_W-1:0]   tb_main, tb_alt;
    logic [DATA_W-1:0] dec_main, dec_hyp;

    assign tb_run = tick & ~freeze;

    // write decode
    always_comb begin
        tb_wr_lo[0] = wr_en && (wr_sel == SEL_TB_LO || wr_sel == SEL_RTC_LO);
        tb_wr_hi[0] = wr_en && (wr_sel == SEL_TB_HI || wr_sel == SEL_RTC_HI);
        tb_wdata[0] = (wr_sel == SEL_RTC_LO) ? (wr_data & RTC_MASK) : wr_data;
        tb_wr_lo[1] = wr_en && (wr_sel == SEL_ATB_LO);
        tb_wr_hi[1] = wr_en && (wr_sel == SEL_ATB_HI);
        tb_wdata[1] = wr_data;
        dn_wr[0]    = wr_en && (wr_sel == SEL_DEC);
        dn_wr[1]    = wr_en && (wr_sel == SEL_HDEC);
    end

    for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
        tbdec_timebase #(.DATA_W(DATA_W)) u_tb (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (tb_run),
            .wr_lo   (tb_wr_lo[g]),
            .wr_hi   (tb_wr_hi[g]),
            .wr_data (tb_wdata[g]),
            .value   (tb_val[g])
        );
    end

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dn
        tbdec_down #(.DATA_W(DATA_W)) u_dn (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .wr_en   (dn_wr[g]),
            .wr_data (wr_data),
            .value   (dn_val[g]),
            .irq     (dn_irq[g])
        );
    end

    assign tb_main  = tb_val[0];
    assign tb_alt   = tb_val[1];
    assign dec_main = dn_val[0];
    assign dec_hyp  = dn_val[1];
    assign dec_irq  = dn_irq[0];
    assign hdec_irq = dn_irq[1];

    // utilisation counter
    always_comb begin
        st_d = st_q;
        if (util_load)  st_d.util = util_value;
        else if (tick)  st_d.util = st_q.util + {{(TB_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign util_count = st_q.util;

    // read mux
    always_comb begin
        case (rd_sel)
            SEL_TB_LO:  rd_data = tb_main[DATA_W-1:0];
            SEL_TB_HI:  rd_data = tb_main[TB_W-1:DATA_W];
            SEL_ATB_LO: rd_data = tb_alt[DATA_W-1:0];
            SEL_ATB_HI: rd_data = tb_alt[TB_W-1:DATA_W];
            SEL_DEC:    rd_data = dec_main;
            SEL_HDEC:   rd_data = dec_hyp;
            SEL_RTC_LO: rd_data = tb_main[DATA_W-1:0] & RTC_MASK;
            SEL_RTC_HI: rd_data = tb_main[TB_W-1:DATA_W];
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tbdec_unit_chk.sv
module tbdec_unit_chk
    import tbdec_pkg::*;
#(
    parameter int unsigned       DATA_W   = 32,
    parameter logic [DATA_W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                freeze,
    input logic                wr_en,
    input logic [SEL_W-1:0]    wr_sel,
    input logic [DATA_W-1:0]   wr_data,
    input logic [SEL_W-1:0]    rd_sel,
    input logic [DATA_W-1:0]   rd_data,
    input logic                util_load,
    input logic [2*DATA_W-1:0] util_value,
    input logic [2*DATA_W-1:0] util_count,
    input logic                dec_irq,
    input logic                hdec_irq,
    input logic [2*DATA_W-1:0] tb_main,
    input logic [2*DATA_W-1:0] tb_alt,
    input logic [DATA_W-1:0]   dec_main,
    input logic [DATA_W-1:0]   dec_hyp
);
    localparam int unsigned MSB = DATA_W - 1;

    logic dec_w, hdec_w, tb_w;
    assign dec_w  = wr_en && (wr_sel == SEL_DEC);
    assign hdec_w = wr_en && (wr_sel == SEL_HDEC);
    assign tb_w   = wr_en && (wr_sel <= SEL_RTC_HI) && (wr_sel != SEL_DEC)
                    && (wr_sel != SEL_HDEC);

    assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dec_w && dec_main == '0) |=> (dec_irq && dec_main == '1));

    assert_dec_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_w && wr_data[MSB] && !dec_main[MSB]) |=> dec_irq);

    assert_hdec_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdec_w && wr_data[MSB] && !dec_hyp[MSB]) |=> hdec_irq);

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !tb_w) |=> ($stable(tb_main) && $stable(tb_alt)));

    assert_dec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_irq |=> !dec_irq);

    assert_hdec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hdec_irq |=> !hdec_irq);

    assert_util_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        util_load |=> (util_count == $past(util_value)));

    assert_rtc_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_RTC_LO) |-> ((rd_data & ~RTC_MASK) == '0));

    assert_unused_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel > SEL_RTC_HI) |-> (rd_data == '0));

    assert_freeze_in_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !freeze && !tb_w) |=> (tb_main != $past(tb_main)));
endmodule

bind tbdec_unit tbdec_unit_chk #(.DATA_W(DATA_W), .RTC_MASK(RTC_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .freeze     (freeze),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .util_load  (util_load),
    .util_value (util_value),
    .util_count (util_count),
    .dec_irq    (dec_irq),
    .hdec_irq   (hdec_irq),
    .tb_main    (tb_main),
    .tb_alt     (tb_alt),
    .dec_main   (dec_main),
    .dec_hyp    (dec_hyp)
);

// File: tb/tbdec_unit_test.sv
module tbdec_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        util_load = 1'b0;
    logic [63:0] util_value = '0;
    logic [63:0] util_count;
    logic        dec_irq, hdec_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbdec_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .util_load(util_load), .util_value(util_value), .util_count(util_count),
        .dec_irq(dec_irq), .hdec_irq(hdec_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [31:0] val);
        rd_sel = sel; #1; val = rd_data;
    endtask

    task automatic rd64(input logic [3:0] lo_sel, output logic [63:0] val);
        logic [31:0] lo, hi;
        rd(lo_sel, lo);
        rd(lo_sel + 4'd1, hi);
        val = {hi, lo};
    endtask

    task automatic t_reset();
        logic [63:0] v;
        logic [31:0] w;
        rd64(4'd0, v); chk("R1 main time base", v, 64'h0);
        rd64(4'd2, v); chk("R1 alternate time base", v, 64'h0);
        rd(4'd4, w);   chk("R1 decrementer", {32'h0, w}, 64'hFFFF_FFFF);
        rd(4'd5, w);   chk("R1 hyp decrementer", {32'h0, w}, 64'hFFFF_FFFF);
        chk("R1 util", util_count, 64'h0);
        chk("R1 irqs", {62'h0, dec_irq, hdec_irq}, 64'h0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        run_ticks(5);
        rd64(4'd0, v); chk("R2 five ticks", v, 64'd5);
        wr(4'd0, 32'hFFFF_FFFE);
        wr(4'd1, 32'h0000_0007);
        run_ticks(3);
        rd64(4'd0, v); chk("R2 carry into high word", v, 64'h0000_0008_0000_0001);
    endtask

    task automatic t_halves();
        logic [63:0] v;
        wr(4'd0, 32'h1111_2222);
        wr(4'd1, 32'h0000_ABCD);
        rd64(4'd0, v); chk("R3 high write keeps low", v, 64'h0000_ABCD_1111_2222);
        wr(4'd0, 32'h5);
        rd64(4'd0, v); chk("R3 low write keeps high", v, 64'h0000_ABCD_0000_0005);
        tick = 1'b1;
        wr(4'd0, 32'd100);
        tick = 1'b0;
        rd64(4'd0, v); chk("R3 write beats tick", v, 64'h0000_ABCD_0000_0064);
    endtask

    task automatic t_alt();
        logic [63:0] v;
        wr(4'd0, 32'h10); wr(4'd1, 32'h0);
        wr(4'd3, 32'h55); wr(4'd2, 32'h66);
        rd64(4'd2, v); chk("R4 alternate written", v, 64'h0000_0055_0000_0066);
        rd64(4'd0, v); chk("R4 main untouched", v, 64'h10);
        run_ticks(2);
        rd64(4'd2, v); chk("R4 alternate counts", v, 64'h0000_0055_0000_0068);
        rd64(4'd0, v); chk("R4 main counts", v, 64'h12);
    endtask

    task automatic t_freeze();
        logic [63:0] v;
        wr(4'd0, 32'h10); wr(4'd1, 32'h0);
        wr(4'd2, 32'h20); wr(4'd3, 32'h0);
        freeze = 1'b1;
        run_ticks(4);
        rd64(4'd0, v); chk("R5 main held", v, 64'h10);
        rd64(4'd2, v); chk("R5 alternate held", v, 64'h20);
        freeze = 1'b0;
        run_ticks(2);
        rd64(4'd0, v); chk("R5 main resumes", v, 64'h12);
        rd64(4'd2, v); chk("R5 alternate resumes", v, 64'h22);
    endtask

    task automatic t_dec_wrap();
        logic [31:0] w;
        wr(4'd5, 32'h7000_0000);
        wr(4'd4, 32'd3);
        chk("R7 clear sign write no pulse", {63'h0, dec_irq}, 64'h0);
        run_ticks(3);
        rd(4'd4, w); chk("R6 counted to zero", {32'h0, w}, 64'h0);
        chk("R6 no pulse at zero", {63'h0, dec_irq}, 64'h0);
        run_ticks(1);
        rd(4'd4, w); chk("R6 reload after zero", {32'h0, w}, 64'hFFFF_FFFF);
        chk("R6 wrap pulse", {63'h0, dec_irq}, 64'h1);
        chk("R8 hyp silent on dec wrap", {63'h0, hdec_irq}, 64'h0);
        step();
        chk("R11 dec pulse one cycle", {63'h0, dec_irq}, 64'h0);
    endtask

    task automatic t_dec_write();
        logic [31:0] w;
        wr(4'd4, 32'd5);
        step();
        wr(4'd4, 32'h8000_0000);
        chk("R7 sign set pulse", {63'h0, dec_irq}, 64'h1);
        step();
        chk("R11 dec write pulse one cycle", {63'h0, dec_irq}, 64'h0);
        wr(4'd4, 32'h9000_0000);
        chk("R7 sign already set no pulse", {63'h0, dec_irq}, 64'h0);
        tick = 1'b1;
        wr(4'd4, 32'd10);
        tick = 1'b0;
        rd(4'd4, w); chk("R7 write beats tick", {32'h0, w}, 64'd10);
    endtask

    task automatic t_hdec();
        logic [31:0] w;
        wr(4'd4, 32'h7000_0000);
        wr(4'd5, 32'd1);
        wr(4'd5, 32'hC000_0000);
        chk("R8 hyp sign pulse", {62'h0, hdec_irq, dec_irq}, 64'h2);
        wr(4'd5, 32'd1);
        run_ticks(1);
        rd(4'd5, w); chk("R8 hyp at zero", {32'h0, w}, 64'h0);
        run_ticks(1);
        rd(4'd5, w); chk("R8 hyp reload", {32'h0, w}, 64'hFFFF_FFFF);
        chk("R8 hyp wrap pulse only", {62'h0, hdec_irq, dec_irq}, 64'h2);
        step();
        chk("R11 hyp pulse one cycle", {63'h0, hdec_irq}, 64'h0);
    endtask

    task automatic t_util();
        util_value = 64'h0000_0000_FFFF_FFFF;
        util_load = 1'b1; step(); util_load = 1'b0;
        chk("R9 util load", util_count, 64'h0000_0000_FFFF_FFFF);
        freeze = 1'b1;
        run_ticks(2);
        freeze = 1'b0;
        chk("R9 util counts with carry", util_count, 64'h0000_0001_0000_0001);
        util_value = 64'h1234_5678_9ABC_DEF0;
        tick = 1'b1; util_load = 1'b1; step(); util_load = 1'b0; tick = 1'b0;
        chk("R9 load beats tick", util_count, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_rtc();
        logic [31:0] w;
        logic [63:0] v;
        wr(4'd1, 32'h0000_0042);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd6, w); chk("R10 clock view read mask", {32'h0, w}, 64'h3FFF_FF80);
        rd(4'd7, w); chk("R10 clock view high word", {32'h0, w}, 64'h42);
        wr(4'd6, 32'hFFFF_FFFF);
        rd64(4'd0, v); chk("R10 clock view write mask", v, 64'h0000_0042_3FFF_FF80);
        wr(4'd7, 32'h0000_0099);
        rd64(4'd0, v); chk("R10 clock view high write", v, 64'h0000_0099_3FFF_FF80);
    endtask

    task automatic t_unused();
        logic [63:0] v;
        logic [31:0] w;
        wr(4'd0, 32'hA); wr(4'd1, 32'hB);
        wr(4'd2, 32'hC); wr(4'd3, 32'hD);
        wr(4'd4, 32'hE); wr(4'd5, 32'hF);
        wr(4'd8, 32'hDEAD_BEEF);
        wr(4'd15, 32'hDEAD_BEEF);
        rd(4'd9, w);   chk("R12 unused select reads zero", {32'h0, w}, 64'h0);
        rd64(4'd0, v); chk("R12 main unchanged", v, 64'h0000_000B_0000_000A);
        rd64(4'd2, v); chk("R12 alternate unchanged", v, 64'h0000_000D_0000_000C);
        rd(4'd4, w);   chk("R12 decrementer unchanged", {32'h0, w}, 64'hE);
        rd(4'd5, w);   chk("R12 hyp unchanged", {32'h0, w}, 64'hF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_count();
        t_halves();
        t_alt();
        t_freeze();
        t_dec_wrap();
        t_dec_write();
        t_hdec();
        t_util();
        t_rtc();
        t_unused();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule